// File: doc/BRIEF.md
# Dual-Clock Frame Staging FIFO with Commit and Rollback

This block buffers frames whole between a receive clock domain and a core clock domain. The writer pushes words of the frame in progress. The reader sees none of them until the frame's final word arrives with a good-frame flag. That final word publishes the whole frame at once. A final word with a bad-frame flag discards the frame and gives its space back. The good/bad verdict, for example a frame check result, is produced outside this block.

The writer keeps a speculative pointer of its own. Only the committed pointer crosses to the reader, in Gray code, through a two-stage synchronizer. Words that are pushed but not yet committed already count against the writer's free space.

A frame can outgrow the remaining space. In that case the frame is rolled back when a word arrives with no room left. The rest of that frame is then discarded up to and including its final word. Every frame therefore ends in exactly one publish or one discard. No word of a dropped frame can join the front of the next frame.

Top module: `frameStageFifo`

## Requirements
- R1: After reset, wrFree equals the capacity (2^ADDR_BITS, 512 by default), rdEmpty is 1 and rdCount is 0.
- R2: Each word accepted from the writer lowers wrFree by one from the next write clock. Uncommitted words are included in this count.
- R3: While a frame is uncommitted, none of its words is visible: rdEmpty stays 1 and rdCount stays unchanged.
- R4: A word with wrValid=1, wrLast=1 and wrGood=1 is stored and commits the frame. All of its words then become readable, in push order, and rdCount includes them.
- R5: A word with wrValid=1, wrLast=1 and wrGood=0 rolls the frame back. wrFree returns to its value before the frame, and no word of the frame is ever read.
- R6: A word that arrives while wrFree is 0, and the frame is not already being discarded, rolls back the frame in progress. wrFree returns to its value before the frame.
- R7: After such a full-triggered rollback, later words of that frame are ignored up to and including the word with wrLast=1. The next frame is then stored intact, with no leftover words.
- R8: A frame whose length exactly equals the free space is committed. wrFree becomes 0 and rdCount equals the capacity.
- R9: A full-triggered rollback that falls on a word with wrLast=1 ends that frame. The very next word starts a new frame, which is accepted normally.
- R10: While rdEmpty is 0, rdData shows the oldest committed word, and rdEn=1 removes it at the next read clock edge. rdEn while rdEmpty is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| wrRstN | input | 1 | Write-side reset, active low |
| wrValid | input | 1 | A word is offered this cycle |
| wrData | input | WIDTH | Word data |
| wrLast | input | 1 | Offered word is the final word of its frame |
| wrGood | input | 1 | Verdict for the frame, sampled with wrLast: 1 publish, 0 discard |
| wrFree | output | ADDR_BITS+1 | Free words seen by the writer, including space used by uncommitted words |
| rdClk | input | 1 | Read-side clock |
| rdRstN | input | 1 | Read-side reset, active low |
| rdEn | input | 1 | Remove the oldest word |
| rdData | output | WIDTH | Oldest committed word |
| rdEmpty | output | 1 | No committed word is available |
| rdCount | output | ADDR_BITS+1 | Committed words available to the reader |

## Verification
Two things can land in the same write cycle: a rollback caused by the FIFO being full, and a frame's final word. The bench provokes this with the reader stalled. It commits a 500-word frame, then sends a 13-word frame whose thirteenth word, the one carrying wrLast, arrives with no space left. The outcome is judged by three things: wrFree must return to 12, only the 500 committed words may be readable, and a following 4-word frame must be accepted and read out intact. A wrongly entered discard state would show up as a missing frame.

// File: rtl/cfifoPkg.sv
package cfifoPkg;
  // Strobes the write control hands to the datapath each write cycle
  typedef struct packed {
    logic push;      // store wrData at the speculative pointer
    logic commit;    // publish everything up to and including this push
    logic rollback;  // restore speculative pointer to committed pointer
  } wrStrobe_t;
endpackage

// File: rtl/cfifoSync.sv
module cfifoSync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/cfifoWrCtrl.sv
module cfifoWrCtrl
  import cfifoPkg::*;
#(
  parameter int ADDR_BITS = 9
) (
  input  logic               wrClk,
  input  logic               wrRstN,
  input  logic               wrValid,
  input  logic               wrLast,
  input  logic               wrGood,
  input  logic [ADDR_BITS:0] wrFree,
  output wrStrobe_t          strobe,
  output logic               dropMode
);
  logic full;
  assign full = (wrFree == '0);

  always_comb begin
    strobe = '0;
    if (wrValid && !dropMode) begin
      if (full) begin
        strobe.rollback = 1'b1;
      end else begin
        strobe.push = 1'b1;
        if (wrLast) begin
          strobe.commit   = wrGood;
          strobe.rollback = !wrGood;
        end
      end
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      dropMode <= 1'b0;
    end else if (wrValid) begin
      if (dropMode) begin
        if (wrLast) dropMode <= 1'b0;
      end else if (full && !wrLast) begin
        dropMode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfifoDatapath.sv
module cfifoDatapath
  import cfifoPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int ADDR_BITS = 9
) (
  input  logic               wrClk,
  input  logic               wrRstN,
  input  wrStrobe_t          strobe,
  input  logic [WIDTH-1:0]   wrData,
  output logic [ADDR_BITS:0] wrFree,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  logic               rdEn,
  output logic [WIDTH-1:0]   rdData,
  output logic               rdEmpty,
  output logic [ADDR_BITS:0] rdCount
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int PW    = ADDR_BITS + 1;
  localparam logic [ADDR_BITS:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [ADDR_BITS:0] toGray(input logic [ADDR_BITS:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [ADDR_BITS:0] toBin(input logic [ADDR_BITS:0] g);
    logic [ADDR_BITS:0] b;
    b[ADDR_BITS] = g[ADDR_BITS];
    for (int i = ADDR_BITS - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // Write domain
  logic [ADDR_BITS:0] specPtr, commitPtr, commitGray, specInc;
  logic [ADDR_BITS:0] rdGraySyncW, rdPtrW;
  assign specInc = specPtr + 1'b1;

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[specPtr[ADDR_BITS-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      specPtr    <= '0;
      commitPtr  <= '0;
      commitGray <= '0;
    end else begin
      if (strobe.rollback)  specPtr <= commitPtr;
      else if (strobe.push) specPtr <= specInc;
      if (strobe.commit) begin
        commitPtr  <= specInc;
        commitGray <= toGray(specInc);
      end
    end
  end

  assign rdPtrW = toBin(rdGraySyncW);
  assign wrFree = DEPTH_V - (specPtr - rdPtrW);

  // Read domain
  logic [ADDR_BITS:0] rdPtr, rdGray, commitGraySyncR, commitPtrR, rdNext;
  assign commitPtrR = toBin(commitGraySyncR);
  assign rdCount    = commitPtrR - rdPtr;
  assign rdEmpty    = (rdCount == '0);
  assign rdData     = mem[rdPtr[ADDR_BITS-1:0]];
  assign rdNext     = rdPtr + 1'b1;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (rdEn && !rdEmpty) begin
      rdPtr  <= rdNext;
      rdGray <= toGray(rdNext);
    end
  end

  cfifoSync #(.W(PW)) syncToRd (
    .clk (rdClk), .rstN(rdRstN), .din(commitGray), .dout(commitGraySyncR)
  );
  cfifoSync #(.W(PW)) syncToWr (
    .clk (wrClk), .rstN(wrRstN), .din(rdGray), .dout(rdGraySyncW)
  );
endmodule

// File: rtl/frameStageFifo.sv
module frameStageFifo
  import cfifoPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int ADDR_BITS = 9
) (
  input  logic               wrClk,
  input  logic               wrRstN,
  input  logic               wrValid,
  input  logic [WIDTH-1:0]   wrData,
  input  logic               wrLast,
  input  logic               wrGood,
  output logic [ADDR_BITS:0] wrFree,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  logic               rdEn,
  output logic [WIDTH-1:0]   rdData,
  output logic               rdEmpty,
  output logic [ADDR_BITS:0] rdCount
);
  wrStrobe_t strobe;
  logic      dropMode;

  cfifoWrCtrl #(.ADDR_BITS(ADDR_BITS)) ctrl (
    .wrClk, .wrRstN, .wrValid, .wrLast, .wrGood, .wrFree,
    .strobe, .dropMode
  );

  cfifoDatapath #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS)) dp (
    .wrClk, .wrRstN, .strobe, .wrData, .wrFree,
    .rdClk, .rdRstN, .rdEn, .rdData, .rdEmpty, .rdCount
  );
endmodule

// File: rtl/frameStageFifoChk.sv
module frameStageFifoChk
  import cfifoPkg::*;
#(
  parameter int ADDR_BITS = 9
) (
  input logic               wrClk,
  input logic               wrRstN,
  input logic               wrValid,
  input logic               wrLast,
  input logic [ADDR_BITS:0] wrFree,
  input wrStrobe_t          strobe,
  input logic               dropMode,
  input logic               rdClk,
  input logic               rdRstN,
  input logic [ADDR_BITS:0] rdCount
);
  localparam logic [ADDR_BITS:0] CAP = (ADDR_BITS+1)'(1 << ADDR_BITS);

  AST_FREE_BOUND: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFree <= CAP);  // R2
  AST_FREE_IDLE: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!strobe.push && !strobe.rollback) |=> wrFree >= $past(wrFree));  // R2
  AST_SINGLE_END: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !(strobe.commit && strobe.rollback));  // R5
  AST_ROLLBACK_RECLAIM: assert property (@(posedge wrClk) disable iff (!wrRstN)
    strobe.rollback |=> wrFree >= $past(wrFree));  // R5
  AST_FULL_ROLLBACK: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrValid && wrFree == '0 && !dropMode) |-> (strobe.rollback && !strobe.push));  // R6
  AST_DROP_NOPUSH: assert property (@(posedge wrClk) disable iff (!wrRstN)
    dropMode |-> !strobe.push);  // R7
  AST_DROP_EXIT: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (dropMode && wrValid && wrLast) |=> !dropMode);  // R7
  AST_LAST_NODROP: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!dropMode && wrValid && wrLast) |=> !dropMode);  // R9
  AST_RD_BOUND: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdCount <= CAP);  // R10
endmodule

bind frameStageFifo frameStageFifoChk #(.ADDR_BITS(ADDR_BITS)) chk (.*);

// File: tb/frameStageFifo_test.sv
module frameStageFifo_test;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int W  = 32;
  localparam int AB = 9;
  localparam int CAP = 1 << AB;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic wrValid = 0, wrLast = 0, wrGood = 0, rdEn = 0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic [AB:0]  wrFree, rdCount;
  logic         rdEmpty;

  int checks = 0, fails = 0;
  logic [W-1:0] expQ[$];

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  frameStageFifo #(.WIDTH(W), .ADDR_BITS(AB)) uut (
    .wrClk, .wrRstN, .wrValid, .wrData, .wrLast, .wrGood, .wrFree,
    .rdClk, .rdRstN, .rdEn, .rdData, .rdEmpty, .rdCount
  );

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor: every word the reader takes must match the queue head (R4, R7, R10)
  always @(negedge rdClk) begin
    if (rdRstN && rdEn && !rdEmpty) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected word actual=%0h expected=none", rdData);
      end else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL R10 read order actual=%0h expected=%0h", rdData, e);
        end
      end
    end
  end

  task automatic sendWords(int n, int base, bit endIt, bit good, bit keep);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrValid = 1; wrData = W'(base + i);
      wrLast = endIt && (i == n - 1); wrGood = good;
      if (keep) expQ.push_back(W'(base + i));
    end
    @(negedge wrClk);
    wrValid = 0; wrLast = 0; wrGood = 0;
  endtask

  task automatic setRd(bit v);
    @(posedge rdClk); #1 rdEn = v;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic drain();
    setRd(1);
    while (expQ.size() != 0) @(negedge rdClk);
    setRd(0);
    settle();
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge wrClk);
    wrRstN = 1; rdRstN = 1;
    settle();
    checkEq("R1 wrFree", wrFree, CAP);
    checkEq("R1 rdEmpty", rdEmpty, 1);
    checkEq("R1 rdCount", rdCount, 0);

    // Partial frame stays private
    sendWords(3, 'h100, 0, 1, 1);
    checkEq("R2 wrFree partial", wrFree, CAP - 3);
    settle();
    checkEq("R3 rdEmpty uncommitted", rdEmpty, 1);
    sendWords(1, 'h103, 1, 1, 1);
    checkEq("R2 wrFree after last", wrFree, CAP - 4);
    settle();
    checkEq("R4 rdCount committed", rdCount, 4);
    drain();
    checkEq("R10 wrFree drained", wrFree, CAP);

    // Bad frame with reader polling an empty FIFO
    setRd(1);
    sendWords(5, 'h200, 1, 0, 0);
    settle();
    checkEq("R5 wrFree restored", wrFree, CAP);
    checkEq("R5 rdEmpty", rdEmpty, 1);
    checkEq("R10 rdCount empty reads", rdCount, 0);
    sendWords(1, 'h300, 1, 1, 1);
    sendWords(7, 'h310, 1, 1, 1);
    settle();
    setRd(0);
    checkEq("R4 frames read", expQ.size(), 0);

    // Overflow mid-frame, tail ignored, next frame intact
    sendWords(520, 'h1000, 1, 1, 0);
    settle();
    checkEq("R6 wrFree after overflow", wrFree, CAP);
    checkEq("R6 rdEmpty after overflow", rdEmpty, 1);
    sendWords(6, 'h2000, 1, 1, 1);
    settle();
    checkEq("R7 rdCount next frame", rdCount, 6);
    drain();

    // Exact fit
    sendWords(CAP, 'h3000, 1, 1, 1);
    settle();
    checkEq("R8 rdCount full", rdCount, CAP);
    checkEq("R8 wrFree zero", wrFree, 0);
    drain();

    // Full-triggered rollback on the final word
    sendWords(500, 'h4000, 1, 1, 1);
    sendWords(13, 'h5000, 1, 1, 0);
    settle();
    checkEq("R9 wrFree after coincide", wrFree, 12);
    checkEq("R9 rdCount after coincide", rdCount, 500);
    sendWords(4, 'h6000, 1, 1, 1);
    settle();
    checkEq("R9 rdCount next frame", rdCount, 504);
    drain();
    checkEq("R4 scoreboard empty", expQ.size(), 0);
    checkEq("R1 wrFree final", wrFree, CAP);
    summary();
  end
endmodule